// File: doc/BRIEF.md
# Shared-Vector Interrupt Request Controller

This block gathers interrupt requests from a set of peripheral events, one external pin, two timers and a software break, and presents a single prioritized vector index with a valid flag to a CPU core. Each source latches into a request bit. A request stays pending until the CPU acknowledges the vector that is being presented, or until software clears it by writing 0. Six of the seven vectors are maskable. Each of these has its own enable bit, and one global disable flag gates all six. The break vector cannot be masked.

Two vectors are each shared by a pair of events, and a control bit picks which event of the pair may set the request. The first pair is a built-in periodic tick, raised every `TICK_DIV` clock cycles, and a display-completion event. The second pair is a conversion-complete event and the external pin. The pin goes through a synchronizer and then an edge detector whose polarity software selects. Both timer overflows feed one timer vector with equal standing.

Software programs the block through a small write port. The CPU takes `irq_vec_o` while `irq_valid_o` is high and pulses `ack_i` to retire that vector's request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During reset and right after its release, `irq_valid_o` is 0.
- R2: With the tick select bit (control register, address 2, bit 0) at 0, a tick sets vector 1 once every `TICK_DIV` cycles, and a display-completion pulse has no effect.
- R3: With the tick select bit at 1, a display-completion pulse sets vector 1, and the tick has no effect.
- R4: With the pin select bit (address 2, bit 1) at 0, a conversion-complete pulse sets vector 4 and pin edges are ignored. With the bit at 1, pin edges set vector 4 and conversion pulses are ignored.
- R5: With the polarity bit (address 2, bit 2) at 0, a low-to-high pin change sets the request. With the bit at 1, a high-to-low change sets it. The request becomes visible after the third rising clock edge following the change, because of two synchronizer stages and one edge stage.
- R6: An overflow pulse from either timer sets vector 5.
- R7: Vector n, for n from 0 to 5, is presented only if its request bit is set, its enable bit (address 1, bit n) is 1, and the global disable flag (address 2, bit 3) is 0.
- R8: The break request (vector 6) has the lowest priority. It has no enable bit and is presented even when the global disable flag is 1.
- R9: When several vectors are eligible, the lowest index is presented. The vector order is serial 0, tick/display 1, slicer 2, I2C 3, conversion/pin 4, timer 5, break 6.
- R10: Pulsing `ack_i` while `irq_valid_o` is 1 clears the request of the presented vector. At address 0, a write clears each request bit n whose data bit n is 0, and a data bit of 1 never sets a request.
- R11: If a vector is set and cleared in the same cycle, by acknowledge or by software write, the request stays set.
- R12: Reset clears all request, enable and select bits and the polarity bit, and sets the global disable flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_req_i | input | 1 | Serial transfer event pulse |
| disp_done_i | input | 1 | Display-completion event pulse |
| slicer_req_i | input | 1 | Data slicer event pulse |
| i2c_req_i | input | 1 | I2C event pulse |
| conv_done_i | input | 1 | Conversion-complete event pulse |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_a_ovf_i | input | 1 | First timer overflow pulse |
| tmr_b_ovf_i | input | 1 | Second timer overflow pulse |
| brk_req_i | input | 1 | Software break request pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 request, 1 enable, 2 control |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_valid_o | output | 1 | A vector is being presented |
| irq_vec_o | output | 3 | Presented vector index |

## Verification
The acknowledge of a pending vector can land in the same cycle as a new event on that vector. The clear and the set then contend for one request bit. The bench provokes this by holding `ack_i` high while the timer vector is presented and pulsing the other timer's overflow during that same cycle. The result is judged correct only if the timer vector is still presented afterwards and a second acknowledge is needed to retire it.

// File: rtl/irq_pkg.sv
// Package: shared constants and types of the interrupt vector controller.
// Assumes vector indices double as priority ranks (lower index wins).
package irq_pkg;

    localparam int NUM_VEC  = 7;
    localparam int NUM_MASK = 6;
    localparam int VEC_W    = $clog2(NUM_VEC);

    typedef enum logic [VEC_W-1:0] {
        VEC_SERIAL = 3'd0,
        VEC_TICK   = 3'd1,
        VEC_SLICER = 3'd2,
        VEC_I2C    = 3'd3,
        VEC_CONV   = 3'd4,
        VEC_TIMER  = 3'd5,
        VEC_BREAK  = 3'd6
    } vec_e;

    localparam logic [1:0] ADDR_REQ  = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    // Control register layout, MSB first: bit3 gdis, bit2 pol, bit1 pin sel, bit0 tick sel.
    typedef struct packed {
        logic gdis;
        logic fall_edge;
        logic pin_sel;
        logic disp_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/irq_tick_gen.sv
// Module: free-running divider that emits a one-cycle pulse every DIV cycles.
// Assumes DIV >= 2; the count restarts at zero on reset.
module irq_tick_gen #(
    parameter int DIV = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the divider and wrap at the last count.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_pin_edge.sv
// Module: synchronizes an asynchronous pin and flags one selected edge.
// Assumes the pin is stable for at least two clock cycles between changes.
// Latency from pin change to edge_o is STAGES clock edges.
module irq_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    // Purpose: shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    assign cur = sync_q[STAGES-1];

    // Purpose: keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Purpose: pick rising or falling change per the polarity control.
    always_comb begin
        if (fall_sel_i) edge_o = prev_q & ~cur;
        else            edge_o = cur & ~prev_q;
    end
endmodule

// File: rtl/irq_req_bank.sv
// Module: bank of latched request bits. Set beats both clear paths.
// Assumes ack_clr_i is one-hot or zero.
module irq_req_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_clr_i,
    input  logic         sw_wr_i,
    input  logic [N-1:0] sw_keep_i,
    output logic [N-1:0] req_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold one request until acknowledge or software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                       req_o[i] <= 1'b0;
            else if (set_i[i])                req_o[i] <= 1'b1;
            else if (ack_clr_i[i])            req_o[i] <= 1'b0;
            else if (sw_wr_i && !sw_keep_i[i]) req_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder, lowest set index wins.
// Assumes N fits in W bits.
module irq_prio_enc #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] elig_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o
);
    // Purpose: scan from highest to lowest so the lowest index is kept.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = W'(i);
        end
    end

    assign valid_o = |elig_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the shared-vector interrupt controller.
// Collects source pulses into request bits, applies enables and the global
// disable flag, and presents the lowest eligible vector index.
// Assumes source pulses are synchronous to clk; ext_pin_i may be asynchronous.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int TICK_DIV    = 4096,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_req_i,
    input  logic              disp_done_i,
    input  logic              slicer_req_i,
    input  logic              i2c_req_i,
    input  logic              conv_done_i,
    input  logic              ext_pin_i,
    input  logic              tmr_a_ovf_i,
    input  logic              tmr_b_ovf_i,
    input  logic              brk_req_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_i,
    output logic              irq_valid_o,
    output logic [VEC_W-1:0]  irq_vec_o
);
    ctrl_t               ctrl_q;
    logic [NUM_MASK-1:0] en_q;
    logic [NUM_VEC-1:0]  req_q;
    logic [NUM_VEC-1:0]  set_vec;
    logic [NUM_VEC-1:0]  ack_clr;
    logic [NUM_VEC-1:0]  elig;
    logic                tick_pulse;
    logic                pin_edge;
    logic                gdis;
    logic                wr_req;
    logic                unused_wr_hi;

    assign gdis         = ctrl_q.gdis;
    assign wr_req       = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_REQ));
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_VEC];

    irq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_pulse)
    );

    irq_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin_i),
        .fall_sel_i (ctrl_q.fall_edge),
        .edge_o     (pin_edge)
    );

    // Purpose: control register; interrupts come out of reset masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{gdis: 1'b1, fall_edge: 1'b0, pin_sel: 1'b0, disp_sel: 1'b0};
        end else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_CTRL)) begin
            ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    // Purpose: per-vector enable bits for the maskable vectors.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         en_q <= '0;
        else if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_EN)) en_q <= wr_data_i[NUM_MASK-1:0];
    end

    // Purpose: route each source, or the selected one of a pair, to its vector.
    always_comb begin
        set_vec             = '0;
        set_vec[VEC_SERIAL] = serial_req_i;
        set_vec[VEC_TICK]   = ctrl_q.disp_sel ? disp_done_i : tick_pulse;
        set_vec[VEC_SLICER] = slicer_req_i;
        set_vec[VEC_I2C]    = i2c_req_i;
        set_vec[VEC_CONV]   = ctrl_q.pin_sel ? pin_edge : conv_done_i;
        set_vec[VEC_TIMER]  = tmr_a_ovf_i | tmr_b_ovf_i;
        set_vec[VEC_BREAK]  = brk_req_i;
    end

    // Purpose: turn an acknowledge into a clear of the presented vector only.
    always_comb begin
        ack_clr = '0;
        if (ack_i && irq_valid_o) ack_clr[irq_vec_o] = 1'b1;
    end

    irq_req_bank #(.N(NUM_VEC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .ack_clr_i (ack_clr),
        .sw_wr_i   (wr_req),
        .sw_keep_i (wr_data_i[NUM_VEC-1:0]),
        .req_o     (req_q)
    );

    // Purpose: maskable vectors need enable and no global disable; break does not.
    always_comb begin
        elig = {req_q[VEC_BREAK], req_q[NUM_MASK-1:0] & en_q & {NUM_MASK{~gdis}}};
    end

    irq_prio_enc #(.N(NUM_VEC), .W(VEC_W)) u_enc (
        .elig_i  (elig),
        .valid_o (irq_valid_o),
        .idx_o   (irq_vec_o)
    );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Module: property checker bound to irq_vector_ctrl.
// Recomputes eligibility from the request bank, enables and disable flag
// and relates it to the encoder output and to the request bank over time.
module irq_vector_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_i,
    input logic       wr_en_i,
    input logic       irq_valid_o,
    input logic [2:0] irq_vec_o,
    input logic [6:0] req_q,
    input logic [5:0] en_q,
    input logic       gdis,
    input logic [6:0] set_vec,
    input logic       tick_pulse
);
    logic [6:0] chk_elig;
    logic [6:0] below_mask;

    assign chk_elig   = {req_q[6], req_q[5:0] & en_q & {6{~gdis}}};
    assign below_mask = (7'd1 << irq_vec_o) - 7'd1;

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> chk_elig[irq_vec_o]); // R7
    AST_NO_HIGHER_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> ((chk_elig & below_mask) == 7'd0)); // R9
    AST_NO_IDLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_elig != 7'd0) |-> irq_valid_o); // R9
    AST_BREAK_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_q[6] |-> irq_valid_o); // R8
    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o && !wr_en_i && !set_vec[irq_vec_o]) |=> !req_q[$past(irq_vec_o)]); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != 7'd0) |=> ((req_q & $past(set_vec)) == $past(set_vec))); // R11
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse); // R2
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .wr_en_i     (wr_en_i),
    .irq_valid_o (irq_valid_o),
    .irq_vec_o   (irq_vec_o),
    .req_q       (req_q),
    .en_q        (en_q),
    .gdis        (gdis),
    .set_vec     (set_vec),
    .tick_pulse  (tick_pulse)
);

// File: tb/tb_irq_vector_ctrl.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module tb_irq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_req_i = 0, disp_done_i = 0, slicer_req_i = 0, i2c_req_i = 0;
    logic       conv_done_i = 0, ext_pin_i = 0, tmr_a_ovf_i = 0, tmr_b_ovf_i = 0, brk_req_i = 0;
    logic       wr_en_i = 0;
    logic [1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       ack_i = 0;
    logic       irq_valid_o;
    logic [2:0] irq_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string    tag;
        bit       valid;
        bit [2:0] vec;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .serial_req_i(serial_req_i), .disp_done_i(disp_done_i),
        .slicer_req_i(slicer_req_i), .i2c_req_i(i2c_req_i),
        .conv_done_i(conv_done_i), .ext_pin_i(ext_pin_i),
        .tmr_a_ovf_i(tmr_a_ovf_i), .tmr_b_ovf_i(tmr_b_ovf_i),
        .brk_req_i(brk_req_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ack_i(ack_i),
        .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o)
    );

    // Monitor: pop each expected item and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (irq_valid_o !== e.valid || (e.valid && irq_vec_o !== e.vec)) begin
                    errors++;
                    $display("FAIL %s: valid=%0b vec=%0d expected valid=%0b vec=%0d",
                             e.tag, irq_valid_o, irq_vec_o, e.valid, e.vec);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(input string tag, input bit valid, input bit [2:0] vec);
        exp_t e;
        e.tag = tag; e.valid = valid; e.vec = vec;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        step(1);
        wr_en_i = 0;
    endtask

    // Bits: 0 serial, 1 display, 2 slicer, 3 i2c, 4 conv, 5 timer a, 6 timer b, 7 break.
    task automatic pulse(input logic [7:0] m);
        {brk_req_i, tmr_b_ovf_i, tmr_a_ovf_i, conv_done_i,
         i2c_req_i, slicer_req_i, disp_done_i, serial_req_i} = m;
        step(1);
        {brk_req_i, tmr_b_ovf_i, tmr_a_ovf_i, conv_done_i,
         i2c_req_i, slicer_req_i, disp_done_i, serial_req_i} = '0;
    endtask

    task automatic ack();
        ack_i = 1;
        step(1);
        ack_i = 0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        step(1);
        expect_out("R1 in reset", 0, 0);
        step(2);
        rst_n = 1;
        step(1);
        expect_out("R1 after reset", 0, 0);

        // R12: the global disable flag is 1 out of reset
        wr(1, 8'h3F);
        pulse(8'h01);
        expect_out("R12 gdis set at reset", 0, 0);
        wr(2, 8'h09);
        wr(2, 8'h01);
        expect_out("R7 serial after unmask", 1, 0);
        ack();
        expect_out("R10 ack clears serial", 0, 0);

        // R8: break ignores the global disable flag
        wr(2, 8'h09);
        pulse(8'h80);
        expect_out("R8 break while disabled", 1, 6);
        ack();
        expect_out("R10 ack clears break", 0, 0);

        // R9: priority order
        wr(2, 8'h01);
        pulse(8'hA4);
        expect_out("R9 slicer first", 1, 2);
        ack();
        expect_out("R9 timer next", 1, 5);
        ack();
        expect_out("R8 break last", 1, 6);
        ack();
        expect_out("R9 all retired", 0, 0);

        // R6 and R10: second timer, software clear, write of 1 does not set
        pulse(8'h40);
        expect_out("R6 timer b", 1, 5);
        wr(0, 8'h5F);
        expect_out("R10 sw write 0 clears", 0, 0);
        wr(0, 8'h7F);
        expect_out("R10 sw write 1 no set", 0, 0);

        // R3: display selected
        pulse(8'h02);
        expect_out("R3 display sets vec1", 1, 1);
        ack();

        // R2: tick selected, display ignored, period measured
        wr(2, 8'h00);
        pulse(8'h02);
        expect_out("R2 display ignored", 0, 0);
        for (int i = 0; i < 5000 && !irq_valid_o; i++) step(1);
        expect_out("R2 tick arrives", 1, 1);
        ack();
        cnt = 1;
        for (int i = 0; i < 5000 && !irq_valid_o; i++) begin
            step(1);
            cnt++;
        end
        checks++;
        if (cnt != 4096) begin
            errors++;
            $display("FAIL R2 tick period: actual %0d expected 4096", cnt);
        end
        ack();
        wr(2, 8'h01);
        wr(0, 8'h00);
        expect_out("R3 tick ignored", 0, 0);

        // R4: conversion selected, pin ignored
        pulse(8'h10);
        expect_out("R4 conversion sets vec4", 1, 4);
        ack();
        ext_pin_i = 1;
        step(5);
        expect_out("R4 pin ignored", 0, 0);
        wr(2, 8'h03);
        pulse(8'h10);
        expect_out("R4 conversion ignored", 0, 0);
        ext_pin_i = 0;
        step(5);
        expect_out("R5 falling ignored at pol 0", 0, 0);
        ext_pin_i = 1;
        step(2);
        expect_out("R5 not yet after two edges", 0, 0);
        step(1);
        expect_out("R5 rising after three edges", 1, 4);
        ack();

        // R5: falling polarity
        wr(2, 8'h07);
        ext_pin_i = 0;
        step(3);
        expect_out("R5 falling at pol 1", 1, 4);
        ack();
        ext_pin_i = 1;
        step(5);
        expect_out("R5 rising ignored at pol 1", 0, 0);

        // R11: set and acknowledge in the same cycle
        pulse(8'h20);
        expect_out("R6 timer a", 1, 5);
        ack_i = 1;
        pulse(8'h40);
        ack_i = 0;
        expect_out("R11 set wins over ack", 1, 5);
        ack();
        expect_out("R11 second ack retires", 0, 0);

        // R7: enable bit gates a pending request
        wr(1, 8'h3E);
        pulse(8'h01);
        expect_out("R7 disabled serial hidden", 0, 0);
        wr(1, 8'h3F);
        expect_out("R7 enabled serial shown", 1, 0);
        ack();
        expect_out("R10 final clear", 0, 0);

        step(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule